// File: doc/BRIEF.md
# Linked Control-Block List Walker

This block walks a chain of DMA control blocks held in memory. It reads through a plain single-outstanding read port whose latency varies. It is given a start address and a one-cycle start pulse. It then reads each control block in turn and emits one record for each data block that the control block describes. Each record carries the block's info word, the entry's status word, the entry's data pointer, the entry index and a last-in-block marker. The payload itself is never touched. A downstream mover consumes the records over a valid/ready handshake.

In memory, a control block is a sequence of 32-bit words at byte addresses. Offset 0 holds the next-block pointer and offset 4 holds the info word. After them come the per-entry pairs: entry i has its status word at offset 8+8i and its data pointer at offset 12+8i. The number of entries in each block is a per-channel setting that is sampled at start. An all-ones next pointer ends the list and gives a one-cycle done pulse. An unaligned control-block pointer ends the walk with an error. In extraction mode, an unaligned data pointer or a length that is not a whole number of 128-byte units also ends the walk with an error. An error gives a one-cycle error pulse and a sticky error flag.

Top module: `dcb_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req`, `rec_valid`, `done_irq`, `err_irq` and `err_flag` are all low.
- R2: For a control block at byte address B, the next pointer is read from B, the info word from B+4, status word i from B+8+8i, and data pointer i from B+12+8i. Every read address is a multiple of 4.
- R3: The entry count (`blk_cnt`, 1 to 15, where 0 is treated as 1) is sampled on an accepted start. Each control block yields exactly that many records, with `rec_idx` running 0 up to count-1. `rec_last` is high only on the final entry of a block.
- R4: Records leave in list order, one block after another, following the next pointers. A next pointer of all ones ends the walk after that block's last record. `done_irq` then pulses for one cycle and `busy` falls.
- R5: A control-block address (the start address or any next pointer) whose bits [2:0] are not zero is never read. The walk stops, `err_irq` pulses for one cycle and `err_flag` rises.
- R6: In extraction mode (`extract`=1, sampled at start), an entry whose data pointer has nonzero bits [2:0] is not emitted. The same holds for an entry whose length field (status bits [15:0]) has nonzero bits [6:0]. The walk stops with `err_irq` and `err_flag`.
- R7: In injection mode (`extract`=0), data pointers and lengths are passed through unchecked.
- R8: `err_flag` stays high until the next accepted start clears it. A start pulse while `busy` is high is ignored.
- R9: While `rec_valid` is high and `rec_ready` is low, the record holds all of its fields unchanged.
- R10: Only one read is outstanding at a time. `mem_req` and `mem_addr` hold steady until a cycle with `mem_rvalid` high completes the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a walk |
| start_addr | input | 32 | Byte address of the first control block |
| blk_cnt | input | 4 | Data-block entries per control block |
| extract | input | 1 | 1 = extraction checks on, 0 = injection |
| mem_req | output | 1 | Read request, held until completed |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Read data |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_info | output | 32 | Info word of the current control block |
| rec_status | output | 32 | Status word of the entry |
| rec_ptr | output | 32 | Data pointer of the entry |
| rec_idx | output | 4 | Entry index within the control block |
| rec_last | output | 1 | Final entry of the control block |
| busy | output | 1 | Walk in progress |
| done_irq | output | 1 | One-cycle pulse at end of list |
| err_irq | output | 1 | One-cycle pulse on abort |
| err_flag | output | 1 | Sticky error indication |

## Verification
The assertions assume that the memory raises `mem_rvalid` only while `mem_req` is high, and that `blk_cnt` and `extract` matter only at the moment of an accepted start. The bench's memory model answers only pending requests, after a random delay of zero to three cycles. It changes the configuration inputs only between walks, except for one deliberate start pulse issued mid-walk. List contents are built arithmetically in a bench-owned word array. Selected words are then corrupted to reach each abort path, so every expected record comes from walking that array by the requirements.

// File: rtl/dcb_walker.sv
module dcb_walker #(
  parameter int AW   = 32,
  parameter int CW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] blk_cnt,
  input  logic          extract,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata,
  output logic          rec_valid,
  input  logic          rec_ready,
  output logic [AW-1:0] rec_info,
  output logic [AW-1:0] rec_status,
  output logic [AW-1:0] rec_ptr,
  output logic [CW-1:0] rec_idx,
  output logic          rec_last,
  output logic          busy,
  output logic          done_irq,
  output logic          err_irq,
  output logic          err_flag
);
  localparam int WW = CW + 2;
  localparam logic [AW-1:0] END_MARK = '1;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_EMIT} st_t;

  st_t           state;
  logic [AW-1:0] base, next_q, info_q, stat_q, ptr_q;
  logic [WW-1:0] wsel;
  logic [CW-1:0] cnt_q;
  logic          ext_q;
  logic [CW:0]   idx_w;
  logic          last_ent, bad_data;

  assign busy       = (state != S_IDLE);
  assign mem_req    = (state == S_READ);
  assign mem_addr   = base + AW'({wsel, 2'b00});
  assign rec_valid  = (state == S_EMIT);
  assign rec_info   = info_q;
  assign rec_status = stat_q;
  assign rec_ptr    = ptr_q;
  assign idx_w      = wsel[WW-1:1] - 1'b1;
  assign rec_idx    = idx_w[CW-1:0];
  assign last_ent   = (wsel == WW'({cnt_q, 1'b1}));
  assign rec_last   = last_ent;
  assign bad_data   = ext_q && ((mem_rdata[2:0] != 3'd0) || (stat_q[6:0] != 7'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      base     <= '0;
      next_q   <= '0;
      info_q   <= '0;
      stat_q   <= '0;
      ptr_q    <= '0;
      wsel     <= '0;
      cnt_q    <= CW'(1);
      ext_q    <= 1'b0;
      done_irq <= 1'b0;
      err_irq  <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      err_irq  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          err_flag <= 1'b0;
          cnt_q    <= (blk_cnt == '0) ? CW'(1) : blk_cnt;
          ext_q    <= extract;
          wsel     <= '0;
          if (start_addr[2:0] != 3'd0) begin
            err_irq  <= 1'b1;
            err_flag <= 1'b1;
          end else begin
            base  <= start_addr;
            state <= S_READ;
          end
        end
        S_READ: if (mem_rvalid) begin
          if (wsel == WW'(0)) begin
            next_q <= mem_rdata;
            wsel   <= wsel + 1'b1;
          end else if (wsel == WW'(1)) begin
            info_q <= mem_rdata;
            wsel   <= wsel + 1'b1;
          end else if (!wsel[0]) begin
            stat_q <= mem_rdata;
            wsel   <= wsel + 1'b1;
          end else begin
            ptr_q <= mem_rdata;
            if (bad_data) begin
              err_irq  <= 1'b1;
              err_flag <= 1'b1;
              state    <= S_IDLE;
            end else begin
              state <= S_EMIT;
            end
          end
        end
        S_EMIT: if (rec_ready) begin
          if (!last_ent) begin
            wsel  <= wsel + 1'b1;
            state <= S_READ;
          end else if (next_q == END_MARK) begin
            done_irq <= 1'b1;
            state    <= S_IDLE;
          end else if (next_q[2:0] != 3'd0) begin
            err_irq  <= 1'b1;
            err_flag <= 1'b1;
            state    <= S_IDLE;
          end else begin
            base  <= next_q;
            wsel  <= '0;
            state <= S_READ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module dcb_walker_chk #(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          rec_valid,
  input logic          rec_ready,
  input logic [AW-1:0] rec_info,
  input logic [AW-1:0] rec_status,
  input logic [AW-1:0] rec_ptr,
  input logic [CW-1:0] rec_idx,
  input logic          busy,
  input logic          done_irq,
  input logic          err_irq,
  input logic          err_flag,
  input logic          ext_q
);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));
  a_r2_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'd0);
  a_r9_rec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_ptr) && $stable(rec_status)
      && $stable(rec_info) && $stable(rec_idx));
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy && !err_irq);
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> err_flag && !busy);
  a_r6_ext_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && ext_q |-> rec_ptr[2:0] == 3'd0 && rec_status[6:0] == 7'd0);
endmodule

bind dcb_walker dcb_walker_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .rec_valid(rec_valid), .rec_ready(rec_ready),
  .rec_info(rec_info), .rec_status(rec_status), .rec_ptr(rec_ptr),
  .rec_idx(rec_idx), .busy(busy), .done_irq(done_irq), .err_irq(err_irq),
  .err_flag(err_flag), .ext_q(ext_q));

// File: tb/sim_dcb_walker.sv
module sim_dcb_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [3:0]  blk_cnt = 4'd1;
  logic        extract = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rec_valid;
  logic        rec_ready = 1'b0;
  logic [31:0] rec_info, rec_status, rec_ptr;
  logic [3:0]  rec_idx;
  logic        rec_last, busy, done_irq, err_irq, err_flag;

  dcb_walker u0 (.*);

  always #10 clk = ~clk;

  logic [31:0] mem [0:255];
  int vectors = 0, fails = 0, reads = 0, cyc = 0, lat = 0;

  logic [31:0] e_info [0:127];
  logic [31:0] e_stat [0:127];
  logic [31:0] e_ptr  [0:127];
  logic [3:0]  e_idx  [0:127];
  logic        e_last [0:127];
  int          n_exp;
  bit          exp_err;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[9:2]];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 1'b0;
      lat = 0;
    end else if (mem_rvalid) begin
      mem_rvalid = 1'b0;
    end else if (mem_req) begin
      if (lat == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd(mem_addr);
        reads++;
        lat = $urandom % 4;
      end else lat--;
    end
  end

  function automatic logic [31:0] blk_base(input int b);
    case (b)
      0: return 32'h200;
      1: return 32'h000;
      2: return 32'h100;
      default: return 32'h300;
    endcase
  endfunction

  task automatic build(input int nblk, input int cnt);
    int ec;
    logic [31:0] a;
    ec = (cnt == 0) ? 1 : cnt;
    for (int w = 0; w < 256; w++) mem[w] = 32'hDEAD_0000 | w;
    for (int b = 0; b < nblk; b++) begin
      a = blk_base(b);
      mem[a[9:2]] = (b == nblk - 1) ? 32'hFFFF_FFFF : blk_base(b + 1);
      mem[a[9:2] + 1] = 32'hC0DE_0000 | (b << 8) | cnt;
      for (int i = 0; i < ec; i++) begin
        mem[a[9:2] + 2 + 2*i] = {8'h5A, 4'(b), 4'(i), 16'(128 * (i + 1))};
        mem[a[9:2] + 3 + 2*i] = 32'h4000_0000 + b * 32'h1000 + i * 32'h40;
      end
    end
  endtask

  task automatic model(input logic [31:0] sa, input int cnt, input bit ext);
    logic [31:0] a, nx, inf, st, p;
    int ec;
    ec = (cnt == 0) ? 1 : cnt;
    n_exp = 0; exp_err = 0; a = sa;
    for (int b = 0; b < 8; b++) begin
      if (a[2:0] != 3'd0) begin exp_err = 1; return; end
      nx  = rd(a);
      inf = rd(a + 4);
      for (int i = 0; i < ec; i++) begin
        st = rd(a + 8 + 8*i);
        p  = rd(a + 12 + 8*i);
        if (ext && (p[2:0] != 3'd0 || st[6:0] != 7'd0)) begin exp_err = 1; return; end
        e_info[n_exp] = inf; e_stat[n_exp] = st; e_ptr[n_exp] = p;
        e_idx[n_exp] = 4'(i); e_last[n_exp] = (i == ec - 1);
        n_exp++;
      end
      if (nx == 32'hFFFF_FFFF) return;
      a = nx;
    end
  endtask

  task automatic walk(input logic [31:0] sa, input int cnt, input bit ext,
                      input bit bp, input bit restart, input string req);
    int got, r0, t;
    bit r, fin, saw_done, saw_err;
    model(sa, cnt, ext);
    got = 0; fin = 0; saw_done = 0; saw_err = 0; t = 0;
    @(negedge clk);
    r0 = reads;
    start = 1'b1; start_addr = sa; blk_cnt = 4'(cnt); extract = ext;
    @(negedge clk);
    start = 1'b0;
    while (!fin && t < 3000) begin
      t++;
      if (done_irq) begin saw_done = 1; fin = 1; end
      if (err_irq)  begin saw_err = 1;  fin = 1; end
      if (restart && t == 5) begin
        start = 1'b1; start_addr = 32'h300; blk_cnt = 4'd7; extract = ~ext;
      end else start = 1'b0;
      r = bp ? 1'($urandom % 2) : 1'b1;
      rec_ready = r;
      if (!fin && rec_valid && r) begin
        if (got < n_exp) begin
          chk(rec_info == e_info[got] && rec_status == e_stat[got] && rec_ptr == e_ptr[got],
              "R2", "record words", rec_ptr, e_ptr[got]);
          chk(rec_idx == e_idx[got] && rec_last == e_last[got],
              "R3", "index/last", {27'd0, rec_last, rec_idx}, {27'd0, e_last[got], e_idx[got]});
        end else chk(0, req, "extra record", 32'(got), 32'(n_exp));
        got++;
      end
      @(negedge clk);
    end
    start = 1'b0; rec_ready = 1'b0;
    chk(got == n_exp, "R4", "record count", 32'(got), 32'(n_exp));
    chk(saw_done == !exp_err && saw_err == exp_err, req, "outcome done/err",
        {30'd0, saw_done, saw_err}, {30'd0, !exp_err, exp_err});
    chk(err_flag == exp_err && !busy, req, "flag/busy after walk",
        {30'd0, err_flag, busy}, {30'd0, exp_err, 1'b0});
    if (sa[2:0] != 3'd0)
      chk(reads == r0, "R5", "reads from misaligned start", 32'(reads - r0), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !rec_valid && !done_irq && !err_irq && !err_flag,
        "R1", "reset outputs", {26'd0, busy, mem_req, rec_valid, done_irq, err_irq, err_flag}, 0);
    rst_n = 1'b1;

    for (int c = 0; c < 16; c++)
      for (int e = 0; e < 2; e++) begin
        build(1 + (c % 3), c);
        walk(blk_base(0), c, 1'(e), 1'(c % 2), 0, "R3");
      end

    build(2, 3);
    walk(32'h204, 3, 1, 0, 0, "R5");
    repeat (10) @(negedge clk);
    chk(err_flag, "R8", "flag sticky while idle", {31'd0, err_flag}, 1);
    walk(blk_base(0), 3, 1, 1, 0, "R8");
    chk(!err_flag, "R8", "flag cleared by start", {31'd0, err_flag}, 0);

    build(3, 4);
    mem[blk_base(1) >> 2] = 32'h104;
    walk(blk_base(0), 4, 0, 1, 0, "R5");

    build(2, 5);
    mem[(blk_base(0) >> 2) + 3 + 2*2] = mem[(blk_base(0) >> 2) + 3 + 2*2] | 32'h4;
    walk(blk_base(0), 5, 1, 1, 0, "R6");
    walk(blk_base(0), 5, 0, 1, 0, "R7");

    build(2, 3);
    mem[(blk_base(1) >> 2) + 2] = mem[(blk_base(1) >> 2) + 2] | 32'h40;
    walk(blk_base(0), 3, 1, 0, 0, "R6");
    walk(blk_base(0), 3, 0, 1, 0, "R7");

    build(3, 6);
    walk(blk_base(0), 6, 0, 1, 1, "R8");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule